// File: doc/BRIEF.md
# Clock and Power Mode Controller

This block decides which clocks run in a small microcontroller core and when the processor may advance. Four operating modes are offered: a fast run mode, a slow run mode, an idle mode and a stop mode. All timing is modelled with clock enables on one reference clock. In the fast run mode every reference cycle counts as a base tick. In the slow run mode and in idle, the base tick is the `slow_tick` strobe, which marks one slow-oscillator cycle. A 1/2/4/8 prescaler turns base ticks into the divided system-clock enable. The processor enable is that divided enable, gated to the two run modes.

Software writes a 2-bit mode command. Idle and stop are left by wake events: edges on three external pins, and also a time-base event when in idle. The controller then returns to the run mode that was active before entry. On leaving stop it passes through a warm-up state, and holds the processor off until the needed oscillator has proven stable. Requests for a low-power mode are refused while a wake event is pending.

Top module: `clkpm_ctrl`

## Requirements
- R1: After reset the mode output is 0 (fast run), both oscillator enables are 1, and with `psc_sel`=0 the processor enable `cpu_ce` is high on every reference cycle.
- R2: `sys_ce` pulses once every 2^`psc_sel` base ticks (select values 0,1,2,3 give ratios 1,2,4,8). A base tick is every reference cycle in mode 0, and `slow_tick` in modes 1 and 2.
- R3: A new `psc_sel` value applies only from the next `sys_ce` pulse. The interval in progress ends at the old ratio.
- R4: In mode 0 (fast run) both oscillator enables are 1 and `cpu_ce` equals `sys_ce`.
- R5: In mode 1 (slow run), `slow_osc_en` is 1, `fast_osc_en` follows `fast_keep`, and `cpu_ce` equals `sys_ce`. A fast-run command (code 0) given in mode 1 is ignored while `fast_ok` is low.
- R6: Mode 2 (idle) is entered with command code 2. In idle, `cpu_ce`=0 and `fast_osc_en`=0, while `slow_osc_en`=1. `tbase_ce` follows `slow_tick`, and `sys_ce` keeps pulsing from slow ticks.
- R7: Mode 3 (stop) is entered with command code 3. In stop, `fast_osc_en`, `slow_osc_en`, `cpu_ce`, `sys_ce` and `tbase_ce` are all 0.
- R8: Pin 0 wakes on a falling edge only. Pin 1 wakes on a rising edge when `edge_pol[0]`=1 and on a falling edge when it is 0. Pin 2 does the same under `edge_pol[1]`. An edge of the other direction has no effect.
- R9: `tmr_wake` wakes the controller only in mode 2. In mode 3 it has no effect.
- R10: A wake from idle returns to mode 0 or mode 1, whichever was active when idle was entered.
- R11: A pin wake in stop moves to mode 4 (warm-up). In warm-up, `cpu_ce`=0 and the return mode's oscillator enable is 1. The controller leaves warm-up for the return mode on the 16th slow tick counted while that oscillator's valid flag (`fast_ok` or `slow_ok`) has stayed high. A low flag restarts the count.
- R12: A wake event sets `wake_pend`, and `wake_ack` clears it. While it is set, command codes 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_ok | input | 1 | Fast oscillator valid flag |
| slow_ok | input | 1 | Slow oscillator valid flag |
| slow_tick | input | 1 | One-cycle strobe per slow-oscillator cycle |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_mode | input | 2 | Requested mode: 0 fast, 1 slow, 2 idle, 3 stop |
| fast_keep | input | 1 | Keep fast oscillator on in slow run |
| psc_sel | input | 2 | Prescaler select, ratio 2^value |
| ext_pin | input | 3 | External wake pins |
| edge_pol | input | 2 | Edge choice for pins 1 and 2 (1 rising, 0 falling) |
| tmr_wake | input | 1 | Time-base / wake-timer event |
| wake_ack | input | 1 | Clears the pending wake flag |
| cpu_ce | output | 1 | Processor clock enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| slow_osc_en | output | 1 | Slow oscillator enable |
| tbase_ce | output | 1 | Time-base and wake-timer clock enable |
| sys_ce | output | 1 | Divided system-clock enable |
| mode_o | output | 3 | Current mode, 0..4 as in R1-style codes above |
| wake_pend | output | 1 | Wake event pending |

## Verification
The prescaler is tried with every select value in fast run, where each reference cycle is a base tick. It is also tried at ratio 2 in slow run, where the interval must grow by the slow-tick spacing; this tells a divider that counts base ticks from one that counts reference cycles. A select change made in the middle of an interval separates boundary-aligned updates from immediate ones. Wake pins are driven in both directions under both polarities, which tells edge-direction logic from mere level-change detection. The warm-up exit is driven with a valid flag that drops partway through the count, so that a restarting count can be told from one that only accumulates.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

  typedef enum logic [2:0] {
    M_FAST = 3'd0,
    M_SLOW = 3'd1,
    M_IDLE = 3'd2,
    M_STOP = 3'd3,
    M_WARM = 3'd4
  } pm_mode_e;

  // number of base ticks per divided-clock period
  function automatic int unsigned div_span(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

  // edge of the chosen direction between two samples
  function automatic logic pin_hit(input logic prev, input logic cur, input logic rise);
    return rise ? (~prev & cur) : (prev & ~cur);
  endfunction

  function automatic logic is_run(input pm_mode_e m);
    return (m == M_FAST) || (m == M_SLOW);
  endfunction

endpackage

// File: rtl/clkpm_wake.sv
module clkpm_wake
  import clkpm_pkg::*;
#(
  parameter int N_PINS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pins,
  input  logic [N_PINS-2:0] pol,
  input  logic              tmr_wake,
  input  logic              idle_now,
  input  logic              wake_ack,
  output logic              pin_edge,
  output logic              wake_ev,
  output logic              pend
);

  logic [N_PINS-1:0] pin_q;
  logic [N_PINS-1:0] pin_d;
  logic [N_PINS-1:0] hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= '1;
      pin_d <= '1;
    end else begin
      pin_q <= pins;
      pin_d <= pin_q;
    end
  end

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      if (i == 0) begin : g_fall_only
        assign hit[i] = pin_hit(pin_d[i], pin_q[i], 1'b0);
      end else begin : g_sel
        assign hit[i] = pin_hit(pin_d[i], pin_q[i], pol[i-1]);
      end
    end
  endgenerate

  assign pin_edge = |hit;
  assign wake_ev  = pin_edge | (tmr_wake & idle_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (wake_ev)  pend <= 1'b1;
    else if (wake_ack) pend <= 1'b0;
  end

endmodule

// File: rtl/clkpm_presc.sv
module clkpm_presc
  import clkpm_pkg::*;
#(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_tick,
  input  logic [PSC_W-1:0] psc_sel,
  output logic             sys_ce
);

  localparam int CNT_W = (1 << PSC_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [PSC_W-1:0] sel_act;

  assign last   = CNT_W'(div_span(32'(sel_act)) - 32'd1);
  assign sys_ce = base_tick && (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      sel_act <= '0;
    end else if (base_tick) begin
      if (sys_ce) begin
        cnt     <= '0;
        sel_act <= psc_sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkpm_fsm.sv
module clkpm_fsm
  import clkpm_pkg::*;
#(
  parameter int STABLE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_mode,
  input  logic       fast_ok,
  input  logic       slow_ok,
  input  logic       slow_tick,
  input  logic       pin_edge,
  input  logic       wake_ev,
  input  logic       pend,
  output pm_mode_e   mode,
  output logic       ret_slow,
  output logic       warm_done
);

  localparam int SW = $clog2(STABLE_TICKS);
  localparam logic [SW-1:0] LAST = SW'(STABLE_TICKS - 1);

  pm_mode_e      nxt;
  pm_mode_e      ret_mode;
  logic [SW-1:0] cnt;
  logic          ret_ok;
  logic          block;

  assign ret_mode  = ret_slow ? M_SLOW : M_FAST;
  assign ret_ok    = ret_slow ? slow_ok : fast_ok;
  assign block     = pend | wake_ev;
  assign warm_done = (mode == M_WARM) && slow_tick && ret_ok && (cnt == LAST);

  always_comb begin
    nxt = mode;
    case (mode)
      M_FAST, M_SLOW: begin
        if (cmd_valid) begin
          case (cmd_mode)
            2'd0: if (mode == M_FAST || fast_ok) nxt = M_FAST;
            2'd1: nxt = M_SLOW;
            2'd2: if (!block) nxt = M_IDLE;
            default: if (!block) nxt = M_STOP;
          endcase
        end
      end
      M_IDLE: if (wake_ev)   nxt = ret_mode;
      M_STOP: if (pin_edge)  nxt = M_WARM;
      M_WARM: if (warm_done) nxt = ret_mode;
      default: nxt = M_FAST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_FAST;
      ret_slow <= 1'b0;
      cnt      <= '0;
    end else begin
      mode <= nxt;
      if (is_run(mode)) ret_slow <= (mode == M_SLOW);
      if (mode != M_WARM || !ret_ok) cnt <= '0;
      else if (slow_tick)            cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/clkpm_ctrl.sv
module clkpm_ctrl
  import clkpm_pkg::*;
#(
  parameter int N_PINS       = 3,
  parameter int PSC_W        = 2,
  parameter int STABLE_TICKS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_ok,
  input  logic              slow_ok,
  input  logic              slow_tick,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_mode,
  input  logic              fast_keep,
  input  logic [PSC_W-1:0]  psc_sel,
  input  logic [N_PINS-1:0] ext_pin,
  input  logic [N_PINS-2:0] edge_pol,
  input  logic              tmr_wake,
  input  logic              wake_ack,
  output logic              cpu_ce,
  output logic              fast_osc_en,
  output logic              slow_osc_en,
  output logic              tbase_ce,
  output logic              sys_ce,
  output logic [2:0]        mode_o,
  output logic              wake_pend
);

  pm_mode_e mode;
  logic     pin_edge;
  logic     wake_ev;
  logic     ret_slow;
  logic     warm_done;
  logic     base_tick;

  clkpm_wake #(.N_PINS(N_PINS)) u_wake (
    .clk      (clk),
    .rst_n    (rst_n),
    .pins     (ext_pin),
    .pol      (edge_pol),
    .tmr_wake (tmr_wake),
    .idle_now (mode == M_IDLE),
    .wake_ack (wake_ack),
    .pin_edge (pin_edge),
    .wake_ev  (wake_ev),
    .pend     (wake_pend)
  );

  clkpm_fsm #(.STABLE_TICKS(STABLE_TICKS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_mode  (cmd_mode),
    .fast_ok   (fast_ok),
    .slow_ok   (slow_ok),
    .slow_tick (slow_tick),
    .pin_edge  (pin_edge),
    .wake_ev   (wake_ev),
    .pend      (wake_pend),
    .mode      (mode),
    .ret_slow  (ret_slow),
    .warm_done (warm_done)
  );

  always_comb begin
    case (mode)
      M_FAST:         base_tick = 1'b1;
      M_SLOW, M_IDLE: base_tick = slow_tick;
      default:        base_tick = 1'b0;
    endcase
  end

  clkpm_presc #(.PSC_W(PSC_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_n),
    .base_tick (base_tick),
    .psc_sel   (psc_sel),
    .sys_ce    (sys_ce)
  );

  always_comb begin
    case (mode)
      M_FAST:  fast_osc_en = 1'b1;
      M_SLOW:  fast_osc_en = fast_keep;
      M_WARM:  fast_osc_en = ~ret_slow;
      default: fast_osc_en = 1'b0;
    endcase
  end

  assign slow_osc_en = (mode != M_STOP);
  assign tbase_ce    = slow_tick & (mode != M_STOP);
  assign cpu_ce      = sys_ce & is_run(mode);
  assign mode_o      = mode;

endmodule

// File: rtl/clkpm_chk.sv
module clkpm_chk #(
  parameter int STABLE_TICKS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       cmd_valid,
  input logic [1:0] cmd_mode,
  input logic       fast_ok,
  input logic       slow_ok,
  input logic       slow_tick,
  input logic       fast_osc_en,
  input logic       slow_osc_en,
  input logic       cpu_ce,
  input logic       sys_ce,
  input logic       tbase_ce,
  input logic       pend,
  input logic       pin_edge,
  input logic       ret_slow
);

  localparam int VW = $clog2(STABLE_TICKS + 1);

  logic [VW-1:0] vcnt;
  logic          ok_ret;

  assign ok_ret = ret_slow ? slow_ok : fast_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      vcnt <= '0;
    else if (mode != 3'd4 || !ok_ret) vcnt <= '0;
    else if (slow_tick && vcnt < VW'(STABLE_TICKS)) vcnt <= vcnt + 1'b1;
  end

  p_fast_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0) |-> (fast_osc_en && slow_osc_en && (cpu_ce == sys_ce)));

  p_slow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd1 && cmd_valid && cmd_mode == 2'd0 && !fast_ok) |=> (mode == 3'd1));

  p_idle_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd2) |-> (!cpu_ce && !fast_osc_en && slow_osc_en && (tbase_ce == slow_tick)));

  p_stop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3) |-> (!fast_osc_en && !slow_osc_en && !cpu_ce && !sys_ce && !tbase_ce));

  p_stop_timer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd3 && !pin_edge) |=> (mode == 3'd3));

  p_warm_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4 && !(slow_tick && ok_ret && vcnt == VW'(STABLE_TICKS - 1))) |=> (mode == 3'd4));

  p_warm_cpu_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd4) |-> !cpu_ce);

  p_enter_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode <= 3'd1 && pend && cmd_valid && cmd_mode[1]) |=> (mode == $past(mode)));

endmodule

bind clkpm_ctrl clkpm_chk #(.STABLE_TICKS(STABLE_TICKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode        (mode_o),
  .cmd_valid   (cmd_valid),
  .cmd_mode    (cmd_mode),
  .fast_ok     (fast_ok),
  .slow_ok     (slow_ok),
  .slow_tick   (slow_tick),
  .fast_osc_en (fast_osc_en),
  .slow_osc_en (slow_osc_en),
  .cpu_ce      (cpu_ce),
  .sys_ce      (sys_ce),
  .tbase_ce    (tbase_ce),
  .pend        (wake_pend),
  .pin_edge    (pin_edge),
  .ret_slow    (ret_slow)
);

// File: tb/sim_clkpm_ctrl.sv
module sim_clkpm_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_ok = 1'b1, slow_ok = 1'b1, slow_tick = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_mode = 2'd0;
  logic       fast_keep = 1'b1;
  logic [1:0] psc_sel = 2'd0;
  logic [2:0] ext_pin = 3'b111;
  logic [1:0] edge_pol = 2'b11;
  logic       tmr_wake = 1'b0, wake_ack = 1'b0;
  logic       cpu_ce, fast_osc_en, slow_osc_en, tbase_ce, sys_ce, wake_pend;
  logic [2:0] mode_o;

  int checks = 0, fails = 0;
  int cyc = 0, last_p = 0, pcnt = 0, cpu_n = 0, tb_n = 0;
  int iv [256];
  bit done = 0;

  always #4 clk = ~clk;

  clkpm_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .fast_ok(fast_ok), .slow_ok(slow_ok),
    .slow_tick(slow_tick), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .fast_keep(fast_keep), .psc_sel(psc_sel), .ext_pin(ext_pin),
    .edge_pol(edge_pol), .tmr_wake(tmr_wake), .wake_ack(wake_ack),
    .cpu_ce(cpu_ce), .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en),
    .tbase_ce(tbase_ce), .sys_ce(sys_ce), .mode_o(mode_o), .wake_pend(wake_pend)
  );

  // slow strobe: one reference cycle in five
  initial begin
    forever begin
      repeat (4) @(posedge clk);
      #1 slow_tick = 1'b1;
      @(posedge clk);
      #1 slow_tick = 1'b0;
    end
  end

  // output monitor, sampled at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (rst_n && sys_ce) begin
        pcnt++;
        iv[pcnt % 256] = cyc - last_p;
        last_p = cyc;
      end
      if (rst_n && cpu_ce) cpu_n++;
      if (rst_n && tbase_ce) tb_n++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [1:0] m);
    @(posedge clk); #1 cmd_valid = 1'b1; cmd_mode = m;
    @(posedge clk); #1 cmd_valid = 1'b0;
    cycles(2);
  endtask

  task automatic pulse_tmr();
    @(posedge clk); #1 tmr_wake = 1'b1;
    @(posedge clk); #1 tmr_wake = 1'b0;
    cycles(2);
  endtask

  task automatic ack();
    @(posedge clk); #1 wake_ack = 1'b1;
    @(posedge clk); #1 wake_ack = 1'b0;
    cycles(1);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(posedge clk); #1 ext_pin[i] = v;
    cycles(4);
  endtask

  task automatic wait_pulses(input int n);
    int p0;
    p0 = pcnt;
    while (pcnt < p0 + n) @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      while (!slow_tick) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int c0;
    cycles(2);
    check("R1 mode", mode_o, 0);
    check("R1 fast_osc_en", fast_osc_en, 1);
    check("R1 slow_osc_en", slow_osc_en, 1);
    c0 = cpu_n;
    cycles(10);
    check("R1 cpu_ce every cycle", cpu_n - c0, 10);
  endtask

  task automatic t_presc_fast();
    int c0, p0;
    for (int s = 0; s < 4; s++) begin
      @(posedge clk); #1 psc_sel = 2'(s);
      wait_pulses(3);
      check($sformatf("R2 fast ratio sel=%0d", s), iv[pcnt % 256], 1 << s);
      c0 = cpu_n; p0 = pcnt;
      wait_pulses(2);
      check("R4 cpu_ce tracks sys_ce", cpu_n - c0, pcnt - p0);
      check("R4 both oscillators on", {30'd0, fast_osc_en, slow_osc_en}, 3);
    end
  endtask

  task automatic t_presc_change();
    int n0;
    wait_pulses(1);
    n0 = pcnt;
    cycles(2);
    @(posedge clk); #1 psc_sel = 2'd0;
    while (pcnt < n0 + 3) @(negedge clk);
    check("R3 interval in flight keeps old ratio", iv[(n0 + 1) % 256], 8);
    check("R3 next interval uses new ratio", iv[(n0 + 2) % 256], 1);
  endtask

  task automatic t_slow();
    @(posedge clk); #1 psc_sel = 2'd1;
    send_cmd(2'd1);
    check("R5 slow mode", mode_o, 1);
    @(posedge clk); #1 fast_keep = 1'b0;
    cycles(1);
    check("R5 fast osc off", fast_osc_en, 0);
    check("R5 slow osc on", slow_osc_en, 1);
    @(posedge clk); #1 fast_keep = 1'b1;
    cycles(1);
    check("R5 fast osc kept", fast_osc_en, 1);
    wait_pulses(3);
    check("R2 slow ratio 2 on slow ticks", iv[pcnt % 256], 10);
    @(posedge clk); #1 fast_ok = 1'b0;
    send_cmd(2'd0);
    check("R5 fast request refused without valid", mode_o, 1);
    @(posedge clk); #1 fast_ok = 1'b1;
    send_cmd(2'd0);
    check("R5 fast request accepted", mode_o, 0);
  endtask

  task automatic t_idle();
    int c0, p0, t0;
    send_cmd(2'd1);
    send_cmd(2'd2);
    check("R6 idle mode", mode_o, 2);
    check("R6 fast osc off", fast_osc_en, 0);
    check("R6 slow osc on", slow_osc_en, 1);
    c0 = cpu_n; p0 = pcnt; t0 = tb_n;
    cycles(40);
    check("R6 cpu halted", cpu_n - c0, 0);
    check("R6 sys_ce still running", (pcnt - p0) > 0, 1);
    check("R6 time base running", tb_n - t0, 8);
    pulse_tmr();
    check("R10 return to slow run", mode_o, 1);
    check("R9 timer wake in idle", wake_pend, 1);
    ack();
    send_cmd(2'd0);
    check("R10 back in fast run", mode_o, 0);
  endtask

  task automatic t_stop();
    int c0, p0, t0;
    set_pin(0, 1'b0);
    ack();
    send_cmd(2'd3);
    check("R7 stop mode", mode_o, 3);
    check("R7 oscillators off", {30'd0, fast_osc_en, slow_osc_en}, 0);
    c0 = cpu_n; p0 = pcnt; t0 = tb_n;
    cycles(30);
    check("R7 no enables in stop", (cpu_n - c0) + (pcnt - p0) + (tb_n - t0), 0);
    pulse_tmr();
    check("R9 timer ignored in stop", mode_o, 3);
    @(posedge clk); #1 fast_ok = 1'b0;
    set_pin(0, 1'b1);
    check("R8 pin0 rising ignored", mode_o, 3);
    set_pin(0, 1'b0);
    check("R11 warm-up entered", mode_o, 4);
    check("R11 fast osc requested", fast_osc_en, 1);
    c0 = cpu_n;
    wait_ticks(20);
    check("R11 no exit without valid", mode_o, 4);
    @(posedge clk); #1 fast_ok = 1'b1;
    wait_ticks(8);
    @(posedge clk); #1 fast_ok = 1'b0;
    @(posedge clk); #1 fast_ok = 1'b1;
    wait_ticks(15);
    cycles(1);
    check("R11 still warming after 15 ticks", mode_o, 4);
    check("R11 cpu held during warm-up", cpu_n - c0, 0);
    wait_ticks(1);
    cycles(2);
    check("R11 exit after 16 stable ticks", mode_o, 0);
    ack();
    set_pin(0, 1'b1);
  endtask

  task automatic t_pins();
    @(posedge clk); #1 edge_pol = 2'b01;
    send_cmd(2'd2);
    set_pin(1, 1'b0);
    check("R8 pin1 falling ignored when rising chosen", mode_o, 2);
    set_pin(1, 1'b1);
    check("R8 pin1 rising wakes", mode_o, 0);
    ack();
    send_cmd(2'd2);
    set_pin(2, 1'b0);
    check("R8 pin2 falling wakes when falling chosen", mode_o, 0);
    ack();
    send_cmd(2'd2);
    set_pin(2, 1'b1);
    check("R8 pin2 rising ignored when falling chosen", mode_o, 2);
    pulse_tmr();
    ack();
  endtask

  task automatic t_block();
    set_pin(1, 1'b0);
    set_pin(1, 1'b1);
    check("R12 pending set by edge", wake_pend, 1);
    send_cmd(2'd2);
    check("R12 idle refused while pending", mode_o, 0);
    send_cmd(2'd3);
    check("R12 stop refused while pending", mode_o, 0);
    ack();
    check("R12 ack clears pending", wake_pend, 0);
    send_cmd(2'd2);
    check("R12 idle accepted after ack", mode_o, 2);
    pulse_tmr();
    ack();
    check("R10 back to fast", mode_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_presc_fast();
    t_presc_change();
    t_slow();
    t_idle();
    t_stop();
    t_pins();
    t_block();
    finish_run();
  end

endmodule